// File: doc/BRIEF.md
# Logarithm Reconstruction Adder

This block forms the final fixed-point magnitude of a floating-point natural logarithm. Upstream logic has already split the argument into an integer exponent term and a reduced mantissa, evaluated the mantissa part as a fixed-point product, and predicted the sign of the result. The block scales the exponent term by a rounded ln(2) constant, lines the product up with the mantissa term, and adds the two. The output is the absolute value of the logarithm, wide enough for a later leading-zero normalisation and rounding step.

Both operands arrive already sign-corrected. The exponent term comes in twice, as itself and as its negation, and the predicted sign picks one of them. The mantissa term arrives with its sign already chosen by that same prediction. As a result the sum is never negative, and no absolute-value stage follows the adder. A parameter adds one output register, and a valid flag travels with the data.

Top module: `log_recon_adder`

## Requirements
- R1: With S the selected exponent term as an unsigned integer, K the ln(2) constant with WF+LN2_GUARD fraction bits, and Y the two's-complement `y_term` with 2*WF+G0 fraction bits, `z_mag` equals S*K*2^(WF+G0-LN2_GUARD) + Y as an unsigned number with 2*WF+G0 fraction bits.
- R2: When `res_neg` is 0 the block uses `exp_term`, and when it is 1 it uses `exp_term_neg`. The input that is not selected has no effect on `z_mag`.
- R3: When the selected exponent term is zero, `z_mag` equals `y_term` exactly.
- R4: For a selected exponent term of magnitude up to 2^(WE-1), and a `y_term` of magnitude below one half that is non-negative whenever the term is zero, the internal sum is non-negative and fits `z_mag` without overflow. This includes heavy cancellation at a term of one.
- R5: With OUT_REG=1, `z_mag` and `out_valid` appear one clock after the input, and `out_valid` is `in_valid` delayed by one clock. With OUT_REG=0, both follow the inputs in the same cycle.
- R6: While `rst_n` is low, the registered variant drives `out_valid` = 0 and `z_mag` = 0.
- R7: In the registered variant, `z_mag` holds its value in any cycle that follows a clock edge at which `in_valid` was 0.
- R8: K equals ln(2)*2^(WF+LN2_GUARD) rounded to the nearest integer. With a term of 1 and Y = 0, `z_mag` equals K*2^(WF+G0-LN2_GUARD).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input operands are valid |
| res_neg | input | 1 | Predicted sign of the logarithm, 1 = negative |
| exp_term | input | WE+1 | Signed exponent term E |
| exp_term_neg | input | WE+1 | Negation of E |
| y_term | input | 2*WF+G0+3 | Sign-selected mantissa product, two's complement |
| out_valid | output | 1 | Output magnitude is valid |
| z_mag | output | WE+2*WF+G0+2 | Magnitude of the logarithm, unsigned fixed point |

## Verification
The exponent scaling and the mantissa term meet in the same addition. The hardest case is when they have opposite signs and a term of one nearly cancels a large negative product, which is where an alignment or sign-extension slip shows. The bench provokes this with directed operands at the term-of-one edge and at the largest term, and with a long random run in which the product's sign is drawn freely whenever the term is non-zero. Each cycle, both a registered and a combinational instance are compared against a behavioural model that computes the constant with floating-point rounding and forms the sum with wide integers.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
   // ln(2) fraction bits, binary point left of the MSB
   localparam logic [63:0] LN2_FRAC64 = 64'hB172_17F7_D1CF_79AB;

   // ln(2) rounded to nearest with fbits fraction bits (fbits <= 60)
   function automatic logic [63:0] ln2_rounded(input int fbits);
      logic [63:0] trunc;
      logic        rbit;
      trunc = LN2_FRAC64 >> (64 - fbits);
      rbit  = LN2_FRAC64[63 - fbits];
      return trunc + {63'd0, rbit};
   endfunction
endpackage

// File: rtl/lrc_exp_select.sv
module lrc_exp_select #(
   parameter int WE = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          res_neg,
   input  logic [WE:0]   exp_term,
   input  logic [WE:0]   exp_term_neg,
   output logic [WE-1:0] sel_mag
);
   logic [WE:0] chosen;

   always_comb begin
      chosen = res_neg ? exp_term_neg : exp_term;
   end

   assign sel_mag = chosen[WE-1:0];

   // R2: the sign prediction must pick a non-negative exponent term
   assert_sel_nonneg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> !chosen[WE]);
endmodule

// File: rtl/lrc_const_mult.sv
module lrc_const_mult #(
   parameter int              WE        = 8,
   parameter int              WC        = 26,
   parameter logic [WC-1:0]   K         = '0,
   parameter int              SHIFT_ADD = 1
) (
   input  logic [WE-1:0]    mag,
   output logic [WE+WC-1:0] prod
);
   localparam int WP = WE + WC;

   if (SHIFT_ADD != 0) begin : g_shift_add
      logic [WP-1:0] acc [0:WC];
      assign acc[0] = '0;
      for (genvar i = 0; i < WC; i++) begin : g_bit
         if (K[i]) begin : g_one
            assign acc[i+1] = acc[i] + (WP'(mag) << i);
         end else begin : g_zero
            assign acc[i+1] = acc[i];
         end
      end
      assign prod = acc[WC];
   end else begin : g_mult
      assign prod = WP'(mag) * WP'(K);
   end
endmodule

// File: rtl/lrc_align_add.sv
module lrc_align_add #(
   parameter int WP = 34,
   parameter int WY = 52,
   parameter int WZ = 59,
   parameter int SH = 23
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [WP-1:0]        prod,
   input  logic signed [WY-1:0] y_term,
   output logic [WZ-1:0]        z_sum
);
   localparam int WS = WZ + 1;

   logic signed [WS-1:0] term_e;
   logic signed [WS-1:0] term_y;
   logic signed [WS-1:0] total;

   // exponent product moved to the mantissa binary point, zero low fill
   assign term_e = $signed(WS'(prod) << SH);
   assign term_y = WS'(y_term);
   assign total  = term_e + term_y;
   assign z_sum  = total[WZ-1:0];

   // R4: the sign-corrected sum is never negative
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> !total[WS-1]);

   // R3: a zero exponent product leaves the mantissa term untouched
   assert_zero_exp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && prod == '0) |-> z_sum == WZ'(y_term));
endmodule

// File: rtl/log_recon_adder.sv
module log_recon_adder #(
   parameter int WE        = 8,
   parameter int WF        = 23,
   parameter int G0        = 3,
   parameter int LN2_GUARD = 3,
   parameter int OUT_REG   = 1,
   parameter int SHIFT_ADD = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic                          res_neg,
   input  logic signed [WE:0]            exp_term,
   input  logic signed [WE:0]            exp_term_neg,
   input  logic signed [2*WF+G0+2:0]     y_term,
   output logic                          out_valid,
   output logic [WE+2*WF+G0+1:0]         z_mag
);
   localparam int WC = WF + LN2_GUARD;
   localparam int WP = WE + WC;
   localparam int WY = 2*WF + G0 + 3;
   localparam int WZ = WE + 2*WF + G0 + 2;
   localparam int SH = 2*WF + G0 - WC;
   localparam logic [WC-1:0] LN2_K = WC'(lrc_pkg::ln2_rounded(WC));

   if (WE < 2) begin : g_chk_we
      $error("log_recon_adder: WE must be at least 2");
   end
   if (WF < 2) begin : g_chk_wf
      $error("log_recon_adder: WF must be at least 2");
   end
   if (G0 < 1 || G0 > 5) begin : g_chk_g0
      $error("log_recon_adder: G0 must lie in 1..5");
   end
   if (LN2_GUARD < 1 || WC > 60) begin : g_chk_guard
      $error("log_recon_adder: constant width out of range");
   end
   if (SH < 0) begin : g_chk_shift
      $error("log_recon_adder: constant finer than mantissa term");
   end
   if (OUT_REG < 0 || OUT_REG > 1) begin : g_chk_reg
      $error("log_recon_adder: OUT_REG must be 0 or 1");
   end

   logic [WE-1:0] sel_mag;
   logic [WP-1:0] prod;
   logic [WZ-1:0] z_sum;

   lrc_exp_select #(.WE(WE)) u_sel (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .res_neg      (res_neg),
      .exp_term     (exp_term),
      .exp_term_neg (exp_term_neg),
      .sel_mag      (sel_mag)
   );

   lrc_const_mult #(.WE(WE), .WC(WC), .K(LN2_K), .SHIFT_ADD(SHIFT_ADD)) u_mult (
      .mag  (sel_mag),
      .prod (prod)
   );

   lrc_align_add #(.WP(WP), .WY(WY), .WZ(WZ), .SH(SH)) u_add (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .prod     (prod),
      .y_term   (y_term),
      .z_sum    (z_sum)
   );

   if (OUT_REG != 0) begin : g_reg
      logic          v_q;
      logic [WZ-1:0] z_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            z_q <= '0;
         end else begin
            v_q <= in_valid;
            if (in_valid) begin
               z_q <= z_sum;
            end
         end
      end

      assign out_valid = v_q;
      assign z_mag     = z_q;

      // R5: valid follows the input by exactly one clock
      assert_valid_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> out_valid == $past(in_valid));

      // R7: the output register holds when no operand was taken
      assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !$past(in_valid)) |-> $stable(z_mag));
   end else begin : g_comb
      assign out_valid = in_valid;
      assign z_mag     = z_sum;
   end
endmodule

// File: tb/log_recon_adder_bench.sv
module log_recon_adder_bench;
   localparam int WE = 8;
   localparam int WF = 23;
   localparam int G0 = 3;
   localparam int G1 = 3;
   localparam int WC = WF + G1;
   localparam int WY = 2*WF + G0 + 3;
   localparam int WZ = WE + 2*WF + G0 + 2;
   localparam int FZ = 2*WF + G0;
   localparam int SH = FZ - WC;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic                 in_valid = 1'b0;
   logic                 res_neg = 1'b0;
   logic signed [WE:0]   exp_term = '0;
   logic signed [WE:0]   exp_term_neg = '0;
   logic signed [WY-1:0] y_term = '0;

   logic          v_r, v_c;
   logic [WZ-1:0] z_r, z_c;

   log_recon_adder #(.WE(WE), .WF(WF), .G0(G0), .LN2_GUARD(G1), .OUT_REG(1), .SHIFT_ADD(1))
   u_log_recon_adder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .res_neg(res_neg),
      .exp_term(exp_term), .exp_term_neg(exp_term_neg), .y_term(y_term),
      .out_valid(v_r), .z_mag(z_r)
   );

   log_recon_adder #(.WE(WE), .WF(WF), .G0(G0), .LN2_GUARD(G1), .OUT_REG(0), .SHIFT_ADD(0))
   u_log_recon_adder_comb (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .res_neg(res_neg),
      .exp_term(exp_term), .exp_term_neg(exp_term_neg), .y_term(y_term),
      .out_valid(v_c), .z_mag(z_c)
   );

   int checks = 0;
   int fails = 0;

   function automatic longint ln2_k();
      return longint'($floor($ln(2.0) * (2.0 ** WC) + 0.5));
   endfunction

   function automatic longint model_z(logic sn, logic signed [WE:0] ep,
                                      logic signed [WE:0] en, logic signed [WY-1:0] y);
      longint sel;
      longint r;
      sel = sn ? longint'(en) : longint'(ep);
      r = sel * ln2_k() * (longint'(1) <<< SH) + longint'(y);
      return r & ((longint'(1) <<< WZ) - 1);
   endfunction

   // cycle model of the registered instance
   logic   m_v;
   longint m_z;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_v <= 1'b0;
         m_z <= 0;
      end else begin
         m_v <= in_valid;
         if (in_valid) m_z <= model_z(res_neg, exp_term, exp_term_neg, y_term);
      end
   end

   task automatic chk(string req, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(string req, logic v, logic sn, logic signed [WE:0] ep,
                       logic signed [WE:0] en, logic signed [WY-1:0] y);
      longint ez;
      in_valid = v;
      res_neg = sn;
      exp_term = ep;
      exp_term_neg = en;
      y_term = y;
      #1;
      ez = model_z(sn, ep, en, y);
      chk({req, " R5"}, "comb valid", longint'(v_c), longint'(v));
      if (v) chk(req, "comb z", longint'(z_c), ez);
      @(negedge clk);
      chk({req, " R5"}, "reg valid", longint'(v_r), longint'(m_v));
      chk(req, "reg z", longint'(z_r), m_z);
   endtask

   longint k_sh;
   longint half_max;
   longint big;

   initial begin
      k_sh = ln2_k() * (longint'(1) <<< SH);
      half_max = (longint'(1) <<< (FZ - 1)) - 1;

      repeat (3) @(negedge clk);
      chk("R6", "reset valid", longint'(v_r), 0);
      chk("R6", "reset z", longint'(z_r), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: term of one, zero mantissa term gives the bare constant
      step("R8", 1'b1, 1'b0, 9'sd1, -9'sd1, '0);
      chk("R8", "ln2 constant", longint'(z_r), k_sh);

      // R3: zero exponent term passes the mantissa term through
      step("R3", 1'b1, 1'b0, 9'sd0, 9'sd0, WY'(64'd1234567));
      chk("R3", "zero term pos", longint'(z_r), 1234567);
      step("R3", 1'b1, 1'b1, 9'sd0, 9'sd0, WY'(half_max));
      chk("R3", "zero term neg sign", longint'(z_r), half_max);

      // R2: the unselected exponent input has no effect
      step("R2", 1'b1, 1'b0, 9'sd5, 9'sd77, WY'(64'd100));
      chk("R2", "pick exp_term", longint'(z_r), 5 * k_sh + 100);
      step("R2", 1'b1, 1'b1, 9'sd99, 9'sd7, WY'(-64'sd100));
      chk("R2", "pick exp_term_neg", longint'(z_r), 7 * k_sh - 100);

      // R4: cancellation at a term of one, then the largest term
      step("R4", 1'b1, 1'b1, -9'sd1, 9'sd1, WY'(-half_max));
      chk("R4", "cancel", longint'(z_r), k_sh - half_max);
      big = 128 * k_sh + half_max;
      step("R4", 1'b1, 1'b0, 9'sd128, -9'sd128, WY'(half_max));
      chk("R4", "largest", longint'(z_r), big);

      // R7: idle cycles leave the registered output alone
      step("R7", 1'b0, 1'b1, 9'sd3, -9'sd3, WY'(64'd5));
      chk("R7", "hold 1", longint'(z_r), big);
      step("R7", 1'b0, 1'b0, 9'sd40, -9'sd40, WY'(64'd999));
      chk("R7", "hold 2", longint'(z_r), big);

      // R1: random operands, back to back with idle gaps
      for (int i = 0; i < 400; i++) begin
         automatic int     e   = int'($urandom_range(255, 0)) - 127;
         automatic longint mg  = longint'({$urandom, $urandom}) & half_max;
         automatic logic   sn  = (e < 0) ? 1'b1 : ((e > 0) ? 1'b0 : 1'($urandom_range(1, 0)));
         automatic longint y   = (e != 0 && $urandom_range(1, 0) == 1) ? -mg : mg;
         automatic logic   v   = ($urandom_range(4, 0) != 0);
         step("R1", v, sn, (WE+1)'(e), (WE+1)'(-e), y[WY-1:0]);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule